// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits between an 8-bit CPU with a 16-bit address and the storage on a cartridge. The CPU cannot write to ROM, so its writes to the ROM address range (0x0000-0x7FFF) are taken as control writes instead. From these writes the block sets a switchable ROM bank, an external RAM bank, a RAM-enable flag and a clock-register select. ROM and SRAM sit outside the block. It only forms their physical addresses and a write strobe for the SRAM.

The window at 0xA000-0xBFFF can show one of three things: SRAM, one of five latched clock registers, or an open bus that reads 0xFF. A running time counter (seconds, minutes, hours and a 9-bit day count) advances on a one-cycle tick. A two-step write sequence copies a snapshot of the counter into the readable clock registers.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the switchable ROM bank is 1, the RAM bank is 0, RAM access is disabled and clock access is off. Window reads then return 0xFF and window writes do not assert `sramWe`.
- R2: A write of 0x0A to 0x0000-0x1FFF enables RAM access. A write of 0x00 there disables it. Any other value leaves the enable unchanged.
- R3: A write to 0x2000-0x3FFF stores the value ANDed with 0x7F as the ROM bank, and a result of 0 becomes 1. `romAddr` is {bank, cpuAddr[13:0]} for 0x4000-0x7FFF and {0, cpuAddr[13:0]} for 0x0000-0x3FFF.
- R4: The bank placed on `romAddr` is the stored bank modulo ROM_BANKS (a power of two), so it never points past the ROM. With the default of 32 banks, a stored 0x45 maps to bank 5.
- R5: A write to 0x4000-0x5FFF with a value below RAM_BANKS (4) selects that RAM bank and turns clock access off. Values 0x08-0x0C select clock register (value-8) and turn clock access on. All other values change nothing.
- R6: A window read returns the selected clock register when clock access is on. Otherwise it returns `sramRdData` when RAM is enabled, and 0xFF in every other case.
- R7: A window write goes to the selected clock register when clock access is on, with `sramWe` low. Otherwise `sramWe` is high only when RAM is enabled.
- R8: A write of 0x01 to 0x6000-0x7FFF copies the running time into the clock registers and sets a latched flag, but only when that flag is clear. A write of 0x00 there clears the flag.
- R9: The running counter adds one second per cycle in which `tick1Hz` is high. Seconds and minutes roll over at 60 and hours at 24. Each hour rollover increments the 9-bit day count, which wraps from 511 to 0.
- R10: Clock registers 0-4 hold seconds, minutes, hours, day[7:0] and a control byte. A latch sets the control byte's bit 0 to day[8] and clears bits 3:1. It keeps the upper nibble as it was last written.
- R11: `ramAddr` is {RAM bank, cpuAddr[12:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick1Hz | input | 1 | One-cycle pulse that advances the running seconds |
| cpuAddr | input | 16 | CPU address |
| cpuWrData | input | 8 | CPU write data |
| cpuWe | input | 1 | CPU write strobe |
| sramRdData | input | 8 | Data read from external SRAM |
| romAddr | output | $clog2(ROM_BANKS)+14 | Physical ROM address |
| ramAddr | output | $clog2(RAM_BANKS)+13 | Physical SRAM address |
| sramWe | output | 1 | SRAM write enable |
| cpuRdData | output | 8 | Read data for the external window (0xFF elsewhere) |

## Verification
The assertions assume that `cpuWe` is a clean single-cycle strobe with an address and data that are stable in that cycle. They also assume that `tick1Hz` never coincides with a latch write, so a snapshot never catches a counter in the middle of a carry. The bench drives every input at the falling edge. It keeps each write to exactly one clock cycle and never raises the tick while a control write is in flight. The running time expected at each snapshot comes from a count of the ticks issued so far.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;
  localparam int CLK_REG_COUNT = 5;
  localparam int CLK_SEL_W     = 3;

  // strobes from control to the clock datapath
  typedef struct packed {
    logic                 latchNow;
    logic                 regWr;
    logic [CLK_SEL_W-1:0] regSel;
  } clkStrobe_t;
endpackage

// File: rtl/cart_ctrl.sv
module cart_ctrl
  import cart_bank_pkg::*;
#(
  parameter int ROM_BANKS = 32,
  parameter int RAM_BANKS = 4,
  localparam int ROM_BW = $clog2(ROM_BANKS),
  localparam int RAM_BW = $clog2(RAM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [15:0]          cpuAddr,
  input  logic [7:0]           cpuWrData,
  input  logic                 cpuWe,
  output logic [ROM_BW-1:0]    romBankEff,
  output logic [RAM_BW-1:0]    ramBank,
  output logic                 ramEn,
  output logic                 clkAccess,
  output logic [CLK_SEL_W-1:0] clkSel,
  output clkStrobe_t           strobe
);
  logic [6:0] romBank;
  logic       latched;
  logic       inWindow;
  logic [2:0] region;
  logic [6:0] bankReq;

  assign region   = cpuAddr[15:13];
  assign inWindow = (region == 3'b101);
  assign bankReq  = cpuWrData[6:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      romBank   <= 7'd1;
      ramBank   <= '0;
      ramEn     <= 1'b0;
      clkAccess <= 1'b0;
      clkSel    <= '0;
      latched   <= 1'b0;
    end else if (cpuWe) begin
      case (region)
        3'd0: begin
          if (cpuWrData == 8'h0A)      ramEn <= 1'b1;
          else if (cpuWrData == 8'h00) ramEn <= 1'b0;
        end
        3'd1: romBank <= (bankReq == 7'd0) ? 7'd1 : bankReq;
        3'd2: begin
          if (cpuWrData < 8'(RAM_BANKS)) begin
            ramBank   <= cpuWrData[RAM_BW-1:0];
            clkAccess <= 1'b0;
          end else if (cpuWrData >= 8'h08 && cpuWrData <= 8'h0C) begin
            clkSel    <= CLK_SEL_W'(cpuWrData - 8'h08);
            clkAccess <= 1'b1;
          end
        end
        3'd3: begin
          if (cpuWrData == 8'h01)      latched <= 1'b1;
          else if (cpuWrData == 8'h00) latched <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign romBankEff = romBank[ROM_BW-1:0];

  always_comb begin
    strobe.latchNow = cpuWe && region == 3'd3 && cpuWrData == 8'h01 && !latched;
    strobe.regWr    = cpuWe && inWindow && clkAccess;
    strobe.regSel   = clkSel;
  end

  // R3
  rom_bank_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    romBank != 7'd0);

  // R2
  ram_en_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWe && region == 3'd0 && cpuWrData != 8'h00 && cpuWrData != 8'h0A)
    |=> ramEn == $past(ramEn));

  // R5
  clk_sel_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    clkSel <= CLK_SEL_W'(CLK_REG_COUNT - 1));
endmodule

// File: rtl/cart_clock_counter.sv
module cart_clock_counter #(
  parameter int DAY_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  output logic [5:0]       sec,
  output logic [5:0]       min,
  output logic [4:0]       hour,
  output logic [DAY_W-1:0] day
);
  localparam logic [5:0] SEC_LAST  = 6'd59;
  localparam logic [5:0] MIN_LAST  = 6'd59;
  localparam logic [4:0] HOUR_LAST = 5'd23;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sec  <= '0;
      min  <= '0;
      hour <= '0;
      day  <= '0;
    end else if (tick) begin
      if (sec != SEC_LAST) sec <= sec + 6'd1;
      else begin
        sec <= '0;
        if (min != MIN_LAST) min <= min + 6'd1;
        else begin
          min <= '0;
          if (hour != HOUR_LAST) hour <= hour + 5'd1;
          else begin
            hour <= '0;
            day  <= day + 1'b1;
          end
        end
      end
    end
  end

  // R9
  time_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    sec <= SEC_LAST && min <= MIN_LAST && hour <= HOUR_LAST);

  // R9
  day_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && sec == SEC_LAST && min == MIN_LAST && hour == HOUR_LAST && (&day))
    |=> day == '0);
endmodule

// File: rtl/cart_clock_regs.sv
module cart_clock_regs
  import cart_bank_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  clkStrobe_t           strobe,
  input  logic [7:0]           wrData,
  input  logic [5:0]           sec,
  input  logic [5:0]           min,
  input  logic [4:0]           hour,
  input  logic [8:0]           day,
  output logic [7:0]           rdData
);
  logic [7:0] regs [CLK_REG_COUNT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < CLK_REG_COUNT; i++) regs[i] <= '0;
    end else if (strobe.latchNow) begin
      regs[0] <= {2'b00, sec};
      regs[1] <= {2'b00, min};
      regs[2] <= {3'b000, hour};
      regs[3] <= day[7:0];
      regs[4] <= {regs[4][7:4], 3'b000, day[8]};
    end else if (strobe.regWr) begin
      regs[strobe.regSel] <= wrData;
    end
  end

  assign rdData = (32'(strobe.regSel) < CLK_REG_COUNT) ? regs[strobe.regSel] : 8'hFF;

  // R8
  latch_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchNow |=> regs[0] == {2'b00, $past(sec)} && regs[3] == $past(day[7:0]));

  // R10
  ctrl_layout_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchNow |=> regs[4][3:1] == 3'b000 && regs[4][7:4] == $past(regs[4][7:4]));
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cart_bank_pkg::*;
#(
  parameter int ROM_BANKS = 32,
  parameter int RAM_BANKS = 4,
  localparam int ROM_BW = $clog2(ROM_BANKS),
  localparam int RAM_BW = $clog2(RAM_BANKS),
  localparam int ROM_AW = ROM_BW + 14,
  localparam int RAM_AW = RAM_BW + 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick1Hz,
  input  logic [15:0]       cpuAddr,
  input  logic [7:0]        cpuWrData,
  input  logic              cpuWe,
  input  logic [7:0]        sramRdData,
  output logic [ROM_AW-1:0] romAddr,
  output logic [RAM_AW-1:0] ramAddr,
  output logic              sramWe,
  output logic [7:0]        cpuRdData
);
  logic [ROM_BW-1:0]    romBankEff;
  logic [RAM_BW-1:0]    ramBank;
  logic                 ramEn;
  logic                 clkAccess;
  logic [CLK_SEL_W-1:0] clkSel;
  clkStrobe_t           strobe;
  logic [5:0]           sec, min;
  logic [4:0]           hour;
  logic [8:0]           day;
  logic [7:0]           clkRdData;
  logic                 inWindow;

  cart_ctrl #(.ROM_BANKS(ROM_BANKS), .RAM_BANKS(RAM_BANKS)) uCtrl (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData),
    .cpuWe(cpuWe), .romBankEff(romBankEff), .ramBank(ramBank), .ramEn(ramEn),
    .clkAccess(clkAccess), .clkSel(clkSel), .strobe(strobe)
  );

  cart_clock_counter #(.DAY_W(9)) uCount (
    .clk(clk), .rstN(rstN), .tick(tick1Hz),
    .sec(sec), .min(min), .hour(hour), .day(day)
  );

  cart_clock_regs uRegs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(cpuWrData),
    .sec(sec), .min(min), .hour(hour), .day(day), .rdData(clkRdData)
  );

  assign inWindow = (cpuAddr[15:13] == 3'b101);
  assign romAddr  = cpuAddr[14] ? {romBankEff, cpuAddr[13:0]} : {{ROM_BW{1'b0}}, cpuAddr[13:0]};
  assign ramAddr  = {ramBank, cpuAddr[12:0]};
  assign sramWe   = cpuWe && inWindow && !clkAccess && ramEn;

  always_comb begin
    if (!inWindow)      cpuRdData = 8'hFF;
    else if (clkAccess) cpuRdData = clkRdData;
    else if (ramEn)     cpuRdData = sramRdData;
    else                cpuRdData = 8'hFF;
  end

  // R7
  no_sram_on_clock_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.regWr |-> !sramWe);
endmodule

// File: tb/sim_cart_bank_ctrl.sv
`timescale 1ns/1ps
module sim_cart_bank_ctrl;
  logic        clk = 0;
  logic        rstN = 0;
  logic        tick1Hz = 0;
  logic [15:0] cpuAddr = 0;
  logic [7:0]  cpuWrData = 0;
  logic        cpuWe = 0;
  logic [7:0]  sramRdData = 8'h5A;
  logic [18:0] romAddr;
  logic [14:0] ramAddr;
  logic        sramWe;
  logic [7:0]  cpuRdData;

  int checks = 0, failures = 0;
  int ticks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cart_bank_ctrl u0 (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk); cpuAddr = a; cpuWrData = d; cpuWe = 1;
    @(negedge clk); cpuWe = 0;
  endtask

  task automatic wrSram(string req, logic [15:0] a, logic [7:0] d, bit expWe);
    @(negedge clk); cpuAddr = a; cpuWrData = d; cpuWe = 1;
    #1 chk(req, sramWe, expWe);
    @(negedge clk); cpuWe = 0;
  endtask

  task automatic rd(string req, logic [15:0] a, int exp);
    @(negedge clk); cpuAddr = a; #1 chk(req, cpuRdData, exp);
  endtask

  task automatic romChk(string req, logic [15:0] a, int expBank);
    @(negedge clk); cpuAddr = a; #1 chk(req, romAddr, (expBank << 14) | a[13:0]);
  endtask

  task automatic doTicks(int n);
    @(negedge clk); tick1Hz = 1;
    repeat (n) @(negedge clk);
    tick1Hz = 0; ticks += n;
  endtask

  task automatic latchNow();
    wr(16'h6000, 8'h00); wr(16'h6000, 8'h01);
  endtask

  task automatic checkClock(string req);
    wr(16'h4000, 8'h08); rd(req, 16'hA000, ticks % 60);
    wr(16'h4000, 8'h09); rd(req, 16'hA000, (ticks / 60) % 60);
    wr(16'h4000, 8'h0A); rd(req, 16'hA000, (ticks / 3600) % 24);
    wr(16'h4000, 8'h0B); rd(req, 16'hA000, (ticks / 86400) % 256);
  endtask

  task automatic t_reset();
    romChk("R1", 16'h4123, 1);
    rd("R1", 16'hA010, 8'hFF);
    wrSram("R1", 16'hA000, 8'h11, 0);
    @(negedge clk); cpuAddr = 16'hA123; #1 chk("R1 R11", ramAddr, 16'h0123);
  endtask

  task automatic t_romBank();
    wr(16'h2000, 8'h00); romChk("R3", 16'h7FFF, 1);
    wr(16'h3FFF, 8'h85); romChk("R3", 16'h4001, 5);
    romChk("R3", 16'h2345, 0);
    wr(16'h2100, 8'h3F); romChk("R4", 16'h4000, 8'h1F);
    wr(16'h2100, 8'h45); romChk("R4", 16'h5555, 5);
  endtask

  task automatic t_ramEnable();
    wr(16'h0000, 8'h0A); rd("R2 R6", 16'hA000, 8'h5A);
    wr(16'h1FFF, 8'h33); rd("R2", 16'hBFFF, 8'h5A);
    wr(16'h1000, 8'h00); rd("R2", 16'hA000, 8'hFF);
    wr(16'h0000, 8'h55); rd("R2", 16'hA000, 8'hFF);
    rd("R6", 16'hC000, 8'hFF);
  endtask

  task automatic t_ramBank();
    wr(16'h4000, 8'h02);
    @(negedge clk); cpuAddr = 16'hA123; #1 chk("R5 R11", ramAddr, 15'h4123);
    wr(16'h5000, 8'h05);
    @(negedge clk); cpuAddr = 16'hB001; #1 chk("R5", ramAddr, 15'h5001);
    wr(16'h0000, 8'h0A);
    wr(16'h5FFF, 8'h0D); rd("R5", 16'hA000, 8'h5A);
    wr(16'h4000, 8'h09); rd("R5", 16'hA000, 8'h00);
    wr(16'h4000, 8'h03); rd("R5", 16'hA000, 8'h5A);
    @(negedge clk); cpuAddr = 16'hA000; #1 chk("R5", ramAddr, 15'h6000);
  endtask

  task automatic t_windowWrite();
    wrSram("R7", 16'hA044, 8'h77, 1);
    wr(16'h4000, 8'h0C);
    wrSram("R7", 16'hA000, 8'hF7, 0);
    rd("R6 R7", 16'hB000, 8'hF7);
    wr(16'h4000, 8'h00); wr(16'h0000, 8'h00);
    wrSram("R7", 16'hA000, 8'h12, 0);
  endtask

  task automatic t_latch();
    doTicks(75);
    latchNow(); checkClock("R8");
    wr(16'h4000, 8'h0C); rd("R10", 16'hA000, 8'hF0);
    doTicks(10);
    wr(16'h6000, 8'h01);
    wr(16'h4000, 8'h08); rd("R8", 16'hA000, 15);
    latchNow(); rd("R8", 16'hA000, 25);
  endtask

  task automatic t_rollover();
    doTicks(86400 - ticks + 3661);
    latchNow(); checkClock("R9");
    wr(16'h4000, 8'h0C); rd("R10", 16'hA000, 8'hF0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    t_reset();
    t_romBank();
    t_ramEnable();
    t_ramBank();
    t_windowWrite();
    t_latch();
    t_rollover();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1900000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule